// File: doc/BRIEF.md
# Triggered ADC Conversion Sequencer

This block controls a successive-approximation conversion core that sits outside it. Software configures it through a small write port: a control word carries an enable bit and a start bit, and a channel word selects the analog input. Once enabled and started, the block stays armed. Each rising edge of the hardware trigger input starts exactly one conversion on the selected channel. When the core reports completion, the block captures the result word and raises a single-cycle end-of-conversion interrupt. It then returns to the armed state with start still set, so the next trigger starts the next conversion.

A conversion that is running is abandoned and started again in three cases: a new trigger edge arrives, the channel word is written (even with the same value), or the control word is written with start set. In each case the block pulses the core's abort and start lines in the same cycle, and the partial conversion yields no result. Clearing start during a conversion aborts it and returns to standby with the converter still enabled. Clearing enable returns the block to its stopped state.

All outputs to the core and to software are registered. A write or trigger edge sampled at one clock edge is visible on the outputs right after that edge.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, core_start, core_abort, eoc_irq, busy and result are all 0. While enable is 0, trigger edges are ignored. A control write (reg_addr 0; bit 0 enable, bit 1 start) with enable 0 and start 1 does not set start.
- R2: With enable 1 and start 0, trigger edges are ignored. Writing start 1 arms the block but issues no core_start by itself.
- R3: When the block is armed, a rising trigger edge produces a one-cycle core_start in the cycle after that edge. At the same time core_chan equals the channel word (reg_addr 1, bits [CH_W-1:0]) and busy rises.
- R4: A core_done during a conversion loads core_result into result and gives a one-cycle eoc_irq in the following cycle. busy falls at the same time.
- R5: After completion, start stays set, so the next trigger edge starts a new conversion without any register write.
- R6: A trigger edge during a conversion pulses core_abort and core_start in the same cycle, and busy stays 1.
- R7: A write to the channel word during a conversion restarts it, even if the value is unchanged. The restart pulses abort and start, and core_chan shows the newly written channel.
- R8: A control write with enable 1 and start 1 during a conversion restarts it (abort and start together).
- R9: A control write with enable 1 and start 0 during a conversion pulses core_abort without core_start and drops busy. Afterwards a core_done produces no eoc_irq and leaves result unchanged, and trigger edges are ignored.
- R10: A control write with enable 0 stops the block, aborting any running conversion, and later trigger edges are ignored. A later control write with both bits set arms it again.
- R11: A core_done in the same cycle as a restart or abort event is suppressed: no eoc_irq, and result is unchanged.
- R12: A core_done sampled in the cycle where core_start is high belongs to the abandoned request and is ignored.
- R13: The trigger is edge detected: a trigger held high for several cycles produces only one core_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = channel word |
| reg_wdata | input | WD_W | Write data |
| hw_trig | input | 1 | Hardware trigger, rising edge active |
| core_start | output | 1 | One-cycle start request to the conversion core |
| core_abort | output | 1 | One-cycle abort request to the conversion core |
| core_chan | output | CH_W | Channel for the conversion core |
| core_done | input | 1 | Conversion complete from the core |
| core_result | input | RES_W | Conversion result, valid with core_done |
| result | output | RES_W | Last completed conversion result |
| eoc_irq | output | 1 | One-cycle end-of-conversion interrupt |
| busy | output | 1 | A conversion is in flight |

## Verification
The hardest situations to reach from the ports are collisions: a completion from the core that lands in the same cycle as a restart event, and a completion that lands in the very cycle a new start is issued. The directed bench reaches them by driving core_done on the exact negative edge that also raises the trigger, and by driving it immediately after a restart becomes visible. In both cases it checks that result keeps its earlier value and that no interrupt appears. Restarts caused by rewriting the channel with the same value, and by rewriting start, are driven back to back so that no idle cycle falls between them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_STOP    = 2'd0,
        SEQ_STANDBY = 2'd1,
        SEQ_ARMED   = 2'd2,
        SEQ_CONV    = 2'd3
    } seq_state_t;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CHAN = 1'b1;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_GO_BIT = 1;

    // One cycle worth of register-port activity, decoded.
    typedef struct packed {
        logic ctrl_wr;
        logic chan_wr;
        logic en_val;
        logic go_val;
    } reg_evt_t;

    // Start only takes effect together with enable.
    function automatic logic go_effective(input logic en, input logic go);
        return en & go;
    endfunction

    // Actions the sequencer asks for in a given cycle.
    typedef struct packed {
        logic issue;
        logic abort;
        logic accept_done;
    } seq_act_t;

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic trig_rise
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    assign trig_rise = trig_in & ~trig_q;
endmodule

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 3,
    parameter int WD_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_addr,
    input  logic [WD_W-1:0] reg_wdata,
    output reg_evt_t        evt,
    output logic [CH_W-1:0] chan_q
);
    always_comb begin
        evt.ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
        evt.chan_wr = reg_wr && (reg_addr == ADDR_CHAN);
        evt.en_val  = reg_wdata[CTRL_EN_BIT];
        evt.go_val  = go_effective(reg_wdata[CTRL_EN_BIT], reg_wdata[CTRL_GO_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst)              chan_q <= '0;
        else if (evt.chan_wr) chan_q <= reg_wdata[CH_W-1:0];
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_evt_t evt,
    input  logic     trig_rise,
    input  logic     core_done,
    output logic     core_start,
    output logic     core_abort,
    output logic     done_ok,
    output logic     busy
);
    seq_state_t state_q, state_d;
    seq_act_t   act;

    always_comb begin
        state_d = state_q;
        act     = '0;
        unique case (state_q)
            SEQ_STOP: begin
                if (evt.ctrl_wr && evt.en_val)
                    state_d = evt.go_val ? SEQ_ARMED : SEQ_STANDBY;
            end
            SEQ_STANDBY: begin
                if (evt.ctrl_wr) begin
                    if (!evt.en_val)     state_d = SEQ_STOP;
                    else if (evt.go_val) state_d = SEQ_ARMED;
                end
            end
            SEQ_ARMED: begin
                if (evt.ctrl_wr && !evt.en_val) begin
                    state_d = SEQ_STOP;
                end else if (evt.ctrl_wr && !evt.go_val) begin
                    state_d = SEQ_STANDBY;
                end else if (trig_rise) begin
                    act.issue = 1'b1;
                    state_d   = SEQ_CONV;
                end
            end
            SEQ_CONV: begin
                if (evt.ctrl_wr && !evt.go_val) begin
                    act.abort = 1'b1;
                    state_d   = evt.en_val ? SEQ_STANDBY : SEQ_STOP;
                end else if ((evt.ctrl_wr && evt.go_val) || evt.chan_wr || trig_rise) begin
                    act.abort = 1'b1;
                    act.issue = 1'b1;
                end else if (core_done && !core_start) begin
                    // A done in the issue cycle belongs to the abandoned request.
                    act.accept_done = 1'b1;
                    state_d         = SEQ_ARMED;
                end
            end
            default: state_d = SEQ_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_STOP;
            core_start <= 1'b0;
            core_abort <= 1'b0;
        end else begin
            state_q    <= state_d;
            core_start <= act.issue;
            core_abort <= act.abort;
        end
    end

    assign done_ok = act.accept_done;
    assign busy    = (state_q == SEQ_CONV);
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_ok,
    input  logic [RES_W-1:0] core_result,
    output logic [RES_W-1:0] result,
    output logic             eoc_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            eoc_irq <= 1'b0;
        end else begin
            eoc_irq <= done_ok;
            if (done_ok) result <= core_result;
        end
    end
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int RES_W = 12,
    parameter int WD_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [WD_W-1:0]  reg_wdata,
    input  logic             hw_trig,
    output logic             core_start,
    output logic             core_abort,
    output logic [CH_W-1:0]  core_chan,
    input  logic             core_done,
    input  logic [RES_W-1:0] core_result,
    output logic [RES_W-1:0] result,
    output logic             eoc_irq,
    output logic             busy
);
    reg_evt_t evt;
    logic     trig_rise;
    logic     done_ok;

    adc_trig_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (hw_trig),
        .trig_rise (trig_rise)
    );

    adc_cfg_regs #(.CH_W(CH_W), .WD_W(WD_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .evt       (evt),
        .chan_q    (core_chan)
    );

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .trig_rise  (trig_rise),
        .core_done  (core_done),
        .core_start (core_start),
        .core_abort (core_abort),
        .done_ok    (done_ok),
        .busy       (busy)
    );

    adc_result_reg #(.RES_W(RES_W)) u_res (
        .clk         (clk),
        .rst         (rst),
        .done_ok     (done_ok),
        .core_result (core_result),
        .result      (result),
        .eoc_irq     (eoc_irq)
    );
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk (
    input logic clk,
    input logic rst,
    input logic core_start,
    input logic core_abort,
    input logic core_done,
    input logic eoc_irq,
    input logic busy
);
    p_irq_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |=> !eoc_irq);

    p_irq_needs_done_r4: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |-> $past(core_done));

    p_start_means_busy_r3: assert property (@(posedge clk) disable iff (rst)
        core_start |-> busy);

    p_abort_from_conv_r9: assert property (@(posedge clk) disable iff (rst)
        core_abort |-> $past(busy));

    p_restart_no_irq_r11: assert property (@(posedge clk) disable iff (rst)
        core_abort |-> !eoc_irq);

    p_done_on_issue_r12: assert property (@(posedge clk) disable iff (rst)
        (core_start && core_done) |=> !eoc_irq);

    p_irq_leaves_conv_r4: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |-> !busy);
endmodule

bind adc_trig_seq adc_trig_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_start (core_start),
    .core_abort (core_abort),
    .core_done  (core_done),
    .eoc_irq    (eoc_irq),
    .busy       (busy)
);

// File: tb/adc_trig_seq_tb_top.sv
module adc_trig_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int CH_W  = 3;
    localparam int RES_W = 12;
    localparam int WD_W  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic             reg_addr = 1'b0;
    logic [WD_W-1:0]  reg_wdata = '0;
    logic             hw_trig = 1'b0;
    logic             core_start, core_abort;
    logic [CH_W-1:0]  core_chan;
    logic             core_done = 1'b0;
    logic [RES_W-1:0] core_result = '0;
    logic [RES_W-1:0] result;
    logic             eoc_irq, busy;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_trig_seq #(.CH_W(CH_W), .RES_W(RES_W), .WD_W(WD_W)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .hw_trig(hw_trig), .core_start(core_start),
        .core_abort(core_abort), .core_chan(core_chan), .core_done(core_done),
        .core_result(core_result), .result(result), .eoc_irq(eoc_irq), .busy(busy)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic addr, input logic [WD_W-1:0] d);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
    endtask

    task automatic give_done(input logic [RES_W-1:0] v);
        @(negedge clk);
        core_done = 1'b1; core_result = v;
        @(negedge clk);
        core_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "core_start", core_start, 0);
        chk("R1", "core_abort", core_abort, 0);
        chk("R1", "eoc_irq", eoc_irq, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "result", result, 0);
    endtask

    task automatic t_stop_ignores();
        wr(1'b0, 8'h02);
        pulse_trig();
        chk("R1", "core_start in stop", core_start, 0);
        chk("R1", "busy in stop", busy, 0);
    endtask

    task automatic t_standby();
        wr(1'b0, 8'h01);
        pulse_trig();
        chk("R2", "core_start in standby", core_start, 0);
        wr(1'b0, 8'h03);
        chk("R2", "core_start after arming", core_start, 0);
        chk("R2", "busy after arming", busy, 0);
        wr(1'b1, 8'h05);
    endtask

    task automatic t_first_conv();
        pulse_trig();
        chk("R3", "core_start", core_start, 1);
        chk("R3", "core_chan", core_chan, 5);
        chk("R3", "busy", busy, 1);
        chk("R3", "core_abort", core_abort, 0);
        idle();
        chk("R3", "core_start one cycle", core_start, 0);
        give_done(12'hABC);
        chk("R4", "result", result, 12'hABC);
        chk("R4", "eoc_irq", eoc_irq, 1);
        chk("R4", "busy after done", busy, 0);
        idle();
        chk("R4", "eoc_irq one cycle", eoc_irq, 0);
    endtask

    task automatic t_held_trigger();
        @(negedge clk);
        hw_trig = 1'b1;
        @(negedge clk);
        chk("R5", "new conversion without rewrite", core_start, 1);
        @(negedge clk);
        chk("R13", "held trigger second cycle", core_start, 0);
        @(negedge clk);
        chk("R13", "held trigger third cycle", core_start, 0);
        hw_trig = 1'b0;
        chk("R13", "still busy", busy, 1);
    endtask

    task automatic t_retrigger_and_issue_done();
        pulse_trig();
        chk("R6", "core_abort", core_abort, 1);
        chk("R6", "core_start", core_start, 1);
        chk("R6", "busy", busy, 1);
        core_done = 1'b1; core_result = 12'h111;
        @(negedge clk);
        core_done = 1'b0;
        chk("R12", "eoc_irq on issue-cycle done", eoc_irq, 0);
        chk("R12", "result on issue-cycle done", result, 12'hABC);
        chk("R12", "busy", busy, 1);
    endtask

    task automatic t_chan_rewrite();
        wr(1'b1, 8'h05);
        chk("R7", "abort same chan", core_abort, 1);
        chk("R7", "start same chan", core_start, 1);
        wr(1'b1, 8'h02);
        chk("R7", "core_chan new", core_chan, 2);
        chk("R7", "abort new chan", core_abort, 1);
        chk("R7", "start new chan", core_start, 1);
    endtask

    task automatic t_start_rewrite();
        wr(1'b0, 8'h03);
        chk("R8", "abort", core_abort, 1);
        chk("R8", "start", core_start, 1);
        chk("R8", "busy", busy, 1);
    endtask

    task automatic t_done_with_abort();
        @(negedge clk);
        core_done = 1'b1; core_result = 12'h222; hw_trig = 1'b1;
        @(negedge clk);
        core_done = 1'b0; hw_trig = 1'b0;
        chk("R11", "eoc_irq", eoc_irq, 0);
        chk("R11", "result", result, 12'hABC);
        chk("R11", "restart", core_start, 1);
        give_done(12'h5A5);
        chk("R4", "result second", result, 12'h5A5);
        chk("R4", "eoc_irq second", eoc_irq, 1);
    endtask

    task automatic t_clear_start();
        pulse_trig();
        chk("R9", "start before clear", core_start, 1);
        wr(1'b0, 8'h01);
        chk("R9", "abort", core_abort, 1);
        chk("R9", "no restart", core_start, 0);
        chk("R9", "busy", busy, 0);
        give_done(12'h777);
        chk("R9", "eoc_irq", eoc_irq, 0);
        chk("R9", "result kept", result, 12'h5A5);
        pulse_trig();
        chk("R9", "trigger ignored", core_start, 0);
    endtask

    task automatic t_disable();
        wr(1'b0, 8'h00);
        pulse_trig();
        chk("R10", "trigger in stop", core_start, 0);
        wr(1'b0, 8'h03);
        pulse_trig();
        chk("R10", "re-armed start", core_start, 1);
        wr(1'b0, 8'h00);
        chk("R10", "abort on disable", core_abort, 1);
        chk("R10", "busy", busy, 0);
        pulse_trig();
        chk("R10", "trigger after disable", core_start, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stop_ignores();
        t_standby();
        t_first_conv();
        t_held_trigger();
        t_retrigger_and_issue_done();
        t_chan_rewrite();
        t_start_rewrite();
        t_done_with_abort();
        t_clear_start();
        t_disable();
        repeat (2) idle();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule